// File: doc/BRIEF.md
# Double-Buffered Monochrome Display Store

This block holds two copies of a 64x32 one-bit picture, each stored as 32 rows of 64 bits. The working copy belongs to the sprite drawing logic, which reads and rewrites rows through its own port. The shown copy belongs to the video scan-out, which reads one row at a time through a separate port. Drawing with XOR first erases a sprite and then redraws it. A scan-out that caught the working copy between those two steps would show the blank state, and the picture would flicker.

An arbiter watches a one-cycle pulse that marks each executed draw and a one-cycle tick for each processor cycle. When drawing has gone quiet for a few ticks, or when too many ticks have passed since the last refresh, it starts a copy. The copy moves the whole working copy into the shown copy, one row per clock. Neither port uses a handshake. A row read is always answered one clock later and no copy ever stalls it, so no valid/ready pairs and no back-pressure rules are needed.

Top module: `fb_double_buffer`

## Requirements
- R1: While `rst` is high and after it falls, `copy_busy` is 0 and both buffers read as all-zero rows.
- R2: A working-port write stores `wk_wdata` in row `wk_waddr` at the clock edge. `wk_rdata` returns the row named by `wk_raddr` one clock later. A read of the row being written in the same cycle returns the row as it was before the write.
- R3: `disp_rdata` returns the shown row addressed by `disp_raddr` one clock later, in every cycle, including during a copy. Working-port writes do not reach the shown buffer until a copy moves them.
- R4: A draw pulse marks the working buffer dirty. Once DRAW_QUIET (default 4) ticks have arrived since the latest draw pulse, `copy_busy` rises one clock after the edge that registers the last of those ticks.
- R5: While dirty, a copy also starts once COPY_MAX (default 10) ticks have arrived since the last copy, even if draw pulses keep restarting the quiet count. If that count is already full when a draw pulse arrives, `copy_busy` rises one clock after the edge that registers the pulse.
- R6: Without a draw pulse since the last copy started, no number of ticks starts a copy.
- R7: A copy keeps `copy_busy` high for exactly 32 clocks and moves row k in its k-th busy clock, counting from row 0. A working write to a row that has already been copied shows up only in the working buffer.
- R8: A draw pulse during a copy does not shorten it. Ticks during a copy are ignored. Both tick counts restart from zero when the copy ends, and the pulse leaves the buffer dirty for the next copy.
- R9: The clock after `copy_busy` falls, `copy_busy` is still low. A new copy always needs at least one more tick or draw pulse first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | One pulse per processor cycle |
| draw_pulse | input | 1 | One pulse per executed draw instruction |
| wk_we | input | 1 | Working buffer row write enable |
| wk_waddr | input | 5 | Working buffer write row |
| wk_wdata | input | 64 | Working buffer write data |
| wk_raddr | input | 5 | Working buffer read row |
| wk_rdata | output | 64 | Working buffer read data, one clock latency |
| disp_raddr | input | 5 | Shown buffer read row from scan-out |
| disp_rdata | output | 64 | Shown buffer read data, one clock latency |
| copy_busy | output | 1 | High while a copy is in progress |

## Verification
The arbiter is driven with three tick patterns, and each separates a different trigger. In the first, ticks arrive with no draw, then a single draw arrives when the since-copy count is already full. This tells the dirty gating apart from a plain tick count. In the second, ticks arrive after a single draw, which isolates the quiet trigger; the ticks sent during the preceding copy show whether busy cycles are counted. In the third, draws are spaced two ticks apart, so only the since-copy limit can fire. Reads of the shown buffer are placed before, during and after a copy, and working writes are placed behind the copy pointer. Together they tell apart a correct row-by-row move, a copy that starts early or late, and a scan-out that a copy stalls.

// File: rtl/fbdb_pkg.sv
package fbdb_pkg;
  typedef enum logic {
    CP_IDLE = 1'b0,
    CP_MOVE = 1'b1
  } copy_state_t;
endpackage

// File: rtl/fbdb_arbiter.sv
module fbdb_arbiter #(
  parameter int DRAW_QUIET = 4,
  parameter int COPY_MAX   = 10,
  parameter int CNT_W      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_tick,
  input  logic draw_pulse,
  input  logic busy,
  output logic start
);
  localparam logic [CNT_W-1:0] QUIET_LIM = CNT_W'(DRAW_QUIET);
  localparam logic [CNT_W-1:0] COPY_LIM  = CNT_W'(COPY_MAX);

  logic [CNT_W-1:0] since_draw;
  logic [CNT_W-1:0] since_copy;
  logic             dirty;

  // A copy needs pending changes and one of the two elapsed-tick conditions.
  assign start = !busy && dirty &&
                 ((since_draw >= QUIET_LIM) || (since_copy >= COPY_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      since_draw <= '0;
      since_copy <= '0;
      dirty      <= 1'b0;
    end else begin
      dirty <= draw_pulse | (dirty & ~start);

      if (start || busy || draw_pulse)
        since_draw <= '0;
      else if (cpu_tick && since_draw != QUIET_LIM)
        since_draw <= since_draw + 1'b1;

      if (start || busy)
        since_copy <= '0;
      else if (cpu_tick && since_copy != COPY_LIM)
        since_copy <= since_copy + 1'b1;
    end
  end
endmodule

// File: rtl/fbdb_copier.sv
module fbdb_copier
  import fbdb_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  copy_state_t state;

  assign busy = (state == CP_MOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CP_IDLE;
      row   <= '0;
    end else begin
      case (state)
        CP_IDLE: begin
          if (start) begin
            state <= CP_MOVE;
            row   <= '0;
          end
        end
        CP_MOVE: begin
          row <= row + 1'b1;
          if (row == LAST_ROW) begin
            state <= CP_IDLE;
            row   <= '0;
          end
        end
        default: state <= CP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbdb_work_mem.sv
module fbdb_work_mem #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 64,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [ROW_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic [ROW_W-1:0] tap_addr,
  output logic [WIDTH-1:0] tap_data
);
  logic [WIDTH-1:0] rows_q [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rows_q[g] <= '0;
      else if (we && waddr == ROW_W'(g))
        rows_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rows_q[raddr];
  end

  assign tap_data = rows_q[tap_addr];
endmodule

// File: rtl/fbdb_disp_mem.sv
module fbdb_disp_mem #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 64,
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [ROW_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] rows_q [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rows_q[g] <= '0;
      else if (we && waddr == ROW_W'(g))
        rows_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rows_q[raddr];
  end
endmodule

// File: rtl/fb_double_buffer.sv
module fb_double_buffer #(
  parameter int ROWS       = 32,
  parameter int WIDTH      = 64,
  parameter int DRAW_QUIET = 4,
  parameter int COPY_MAX   = 10,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int CNT_MAX   = (COPY_MAX > DRAW_QUIET) ? COPY_MAX : DRAW_QUIET,
  localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_tick,
  input  logic             draw_pulse,
  input  logic             wk_we,
  input  logic [ROW_W-1:0] wk_waddr,
  input  logic [WIDTH-1:0] wk_wdata,
  input  logic [ROW_W-1:0] wk_raddr,
  output logic [WIDTH-1:0] wk_rdata,
  input  logic [ROW_W-1:0] disp_raddr,
  output logic [WIDTH-1:0] disp_rdata,
  output logic             copy_busy
);
  logic             copy_start;
  logic [ROW_W-1:0] copy_row;
  logic [WIDTH-1:0] copy_data;

  fbdb_arbiter #(
    .DRAW_QUIET(DRAW_QUIET),
    .COPY_MAX  (COPY_MAX),
    .CNT_W     (CNT_W)
  ) u_arb (
    .clk       (clk),
    .rst       (rst),
    .cpu_tick  (cpu_tick),
    .draw_pulse(draw_pulse),
    .busy      (copy_busy),
    .start     (copy_start)
  );

  fbdb_copier #(
    .ROWS (ROWS),
    .ROW_W(ROW_W)
  ) u_copy (
    .clk  (clk),
    .rst  (rst),
    .start(copy_start),
    .busy (copy_busy),
    .row  (copy_row)
  );

  fbdb_work_mem #(
    .ROWS (ROWS),
    .WIDTH(WIDTH),
    .ROW_W(ROW_W)
  ) u_work (
    .clk     (clk),
    .rst     (rst),
    .we      (wk_we),
    .waddr   (wk_waddr),
    .wdata   (wk_wdata),
    .raddr   (wk_raddr),
    .rdata   (wk_rdata),
    .tap_addr(copy_row),
    .tap_data(copy_data)
  );

  fbdb_disp_mem #(
    .ROWS (ROWS),
    .WIDTH(WIDTH),
    .ROW_W(ROW_W)
  ) u_disp (
    .clk  (clk),
    .rst  (rst),
    .we   (copy_busy),
    .waddr(copy_row),
    .wdata(copy_data),
    .raddr(disp_raddr),
    .rdata(disp_rdata)
  );
endmodule

// File: rtl/fbdb_checker.sv
module fbdb_checker #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 64,
  parameter int ROW_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             copy_busy,
  input logic             wk_we,
  input logic [ROW_W-1:0] wk_waddr,
  input logic [WIDTH-1:0] wk_wdata,
  input logic [ROW_W-1:0] wk_raddr,
  input logic [WIDTH-1:0] wk_rdata,
  input logic [ROW_W-1:0] disp_raddr,
  input logic [WIDTH-1:0] disp_rdata
);
  logic [ROW_W:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !copy_busy) busy_len <= '0;
    else                   busy_len <= busy_len + 1'b1;
  end

  AST_COPY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (copy_busy && busy_len == (ROW_W+1)'(ROWS - 1)) |=> !copy_busy); // R7
  AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (copy_busy && busy_len < (ROW_W+1)'(ROWS - 1)) |=> copy_busy); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    $fell(copy_busy) |=> !copy_busy); // R9
  AST_DISP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(!copy_busy) && $stable(disp_raddr)) |=> $stable(disp_rdata)); // R3
  AST_WORK_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(wk_we, 2) && $past(wk_raddr) == $past(wk_waddr, 2) &&
     !($past(wk_we) && $past(wk_waddr) == $past(wk_waddr, 2)))
    |-> wk_rdata == $past(wk_wdata, 2)); // R2
endmodule

bind fb_double_buffer fbdb_checker #(
  .ROWS (ROWS),
  .WIDTH(WIDTH),
  .ROW_W(ROW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .copy_busy (copy_busy),
  .wk_we     (wk_we),
  .wk_waddr  (wk_waddr),
  .wk_wdata  (wk_wdata),
  .wk_raddr  (wk_raddr),
  .wk_rdata  (wk_rdata),
  .disp_raddr(disp_raddr),
  .disp_rdata(disp_rdata)
);

// File: tb/fb_double_buffer_test.sv
module fb_double_buffer_test;
  localparam int ROWS  = 32;
  localparam int WIDTH = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_tick = 1'b0;
  logic              draw_pulse = 1'b0;
  logic              wk_we = 1'b0;
  logic [4:0]        wk_waddr = '0;
  logic [WIDTH-1:0]  wk_wdata = '0;
  logic [4:0]        wk_raddr = '0;
  logic [WIDTH-1:0]  wk_rdata;
  logic [4:0]        disp_raddr = '0;
  logic [WIDTH-1:0]  disp_rdata;
  logic              copy_busy;

  fb_double_buffer uut (
    .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .draw_pulse(draw_pulse),
    .wk_we(wk_we), .wk_waddr(wk_waddr), .wk_wdata(wk_wdata),
    .wk_raddr(wk_raddr), .wk_rdata(wk_rdata),
    .disp_raddr(disp_raddr), .disp_rdata(disp_rdata), .copy_busy(copy_busy)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit              from_disp;
    logic [WIDTH-1:0] exp;
    int              req;
    int              stamp;
  } item_t;
  item_t sb[$];

  function automatic logic [WIDTH-1:0] pat(int r);
    return {8'(r), 24'hC0FFEE, 8'(r * 3), 24'h5A5A17};
  endfunction

  task automatic check(input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops expectations issued in an earlier cycle.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].stamp < cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.from_disp ? disp_rdata : wk_rdata, it.exp, it.req);
    end
  end

  // Driver helpers: enter and leave at a falling edge.
  task automatic push_disp(input int row, input logic [WIDTH-1:0] exp, input int req);
    disp_raddr = 5'(row);
    sb.push_back('{1'b1, exp, req, cyc});
  endtask

  task automatic push_wk(input int row, input logic [WIDTH-1:0] exp, input int req);
    wk_raddr = 5'(row);
    sb.push_back('{1'b0, exp, req, cyc});
  endtask

  task automatic rd_disp(input int row, input logic [WIDTH-1:0] exp, input int req);
    push_disp(row, exp, req);
    @(negedge clk);
  endtask

  task automatic rd_wk(input int row, input logic [WIDTH-1:0] exp, input int req);
    push_wk(row, exp, req);
    @(negedge clk);
  endtask

  task automatic wr_wk(input int row, input logic [WIDTH-1:0] d);
    wk_we = 1'b1; wk_waddr = 5'(row); wk_wdata = d;
    @(negedge clk);
    wk_we = 1'b0;
  endtask

  task automatic do_tick();
    cpu_tick = 1'b1;
    @(negedge clk);
    cpu_tick = 1'b0;
  endtask

  task automatic do_draw();
    draw_pulse = 1'b1;
    @(negedge clk);
    draw_pulse = 1'b0;
  endtask

  task automatic wait_copy(output int n);
    n = 0;
    while (copy_busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [WIDTH-1:0] x_row;
    logic [WIDTH-1:0] y_row;
    int n;
    x_row = 64'hDEAD_BEEF_0BAD_F00D;
    y_row = 64'h0123_4567_89AB_CDEF;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle and blank after reset
    check(64'(copy_busy), 64'd0, 1);
    rd_disp(0, '0, 1);
    rd_wk(5, '0, 1);

    // Fill working buffer without any draw pulse
    for (int r = 0; r < ROWS; r++) wr_wk(r, pat(r));
    rd_wk(3, pat(3), 2);                 // R2 readback
    wk_we = 1'b1; wk_waddr = 5'd7; wk_wdata = ~pat(7);
    push_wk(7, pat(7), 2);               // R2 read-old during write
    @(negedge clk);
    wk_we = 1'b0;
    rd_wk(7, ~pat(7), 2);                // R2 new value visible
    rd_disp(3, '0, 3);                   // R3 shown buffer untouched
    drain();

    // R6: ticks alone never copy (since-copy count saturates)
    repeat (12) do_tick();
    @(negedge clk);
    check(64'(copy_busy), 64'd0, 6);

    // R5 corner: full since-copy count, one draw -> copy one clock later
    do_draw();
    check(64'(copy_busy), 64'd0, 5);
    @(negedge clk);
    check(64'(copy_busy), 64'd1, 5);

    // Copy 1 with activity behind the copy pointer
    n = 0;
    while (copy_busy) begin
      n++;
      wk_we      = (n == 3);
      wk_waddr   = 5'd0;
      wk_wdata   = x_row;
      cpu_tick   = (n >= 6 && n <= 10);  // R8: ignored while busy
      draw_pulse = (n == 8);             // R8: draw mid-copy
      if (n == 5) push_disp(31, '0, 3);  // R3: scan-out not stalled
      @(negedge clk);
    end
    wk_we = 1'b0; cpu_tick = 1'b0; draw_pulse = 1'b0;
    check(64'(n), 64'd32, 7);            // R7 busy length
    @(negedge clk);
    check(64'(copy_busy), 64'd0, 9);     // R9
    rd_disp(0, pat(0), 7);               // R7 row 0 old contents
    rd_disp(7, ~pat(7), 7);
    rd_disp(20, pat(20), 7);
    rd_wk(0, x_row, 7);                  // R7 late write stays in working
    drain();

    // R8 / R4: counters restarted; quiet trigger after 4 ticks
    repeat (3) do_tick();
    @(negedge clk);
    check(64'(copy_busy), 64'd0, 8);
    do_tick();
    check(64'(copy_busy), 64'd0, 4);
    @(negedge clk);
    check(64'(copy_busy), 64'd1, 4);
    wait_copy(n);
    check(64'(n), 64'd32, 7);
    rd_disp(0, x_row, 4);                // R4 dirty row moved by second copy
    drain();

    // R5: draws every two ticks keep quiet count low; since-copy limit fires
    wr_wk(10, y_row);
    for (int i = 0; i < 5; i++) begin
      do_draw();
      do_tick();
      if (i < 4) do_tick();
    end
    @(negedge clk);
    check(64'(copy_busy), 64'd0, 5);
    do_tick();
    check(64'(copy_busy), 64'd0, 5);
    @(negedge clk);
    check(64'(copy_busy), 64'd1, 5);
    wait_copy(n);
    rd_disp(10, y_row, 5);
    drain();

    summary();
  end
endmodule